// File: doc/BRIEF.md
# Bit-Oriented Message Engine

This block handles short repeating code words on the facility data link of an extended-superframe line. On the transmit side it builds a 16-bit message from a 6-bit code held in a register. It sends that message bit by bit, each time the framer asks for a data-link bit, for as long as the enable bit is set. A source selector decides whether the outgoing data-link bit comes from the message generator, the HDLC controller, an external pin or a constant idle level.

On the receive side the block watches the incoming data-link bit stream, which arrives as a bit plus a valid strobe, and recognises framed messages. It accepts a code only when enough of the most recent messages agree on it. An accepted code is stored and compared with a programmable match code. Received and matched events set clear-on-read latch bits and interrupt status bits. The interrupt output is the OR of the status bits that are not masked.

The reset input is asynchronous and active low; its release is synchronised inside the block, so internal state leaves reset two clock edges after `rst_n` rises.

Top module: `bom_engine`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `dl_tx_bit` follows `hdlc_bit` because the source field is zero.
- R2: The source field CTRL[1:0] (address 0) selects `dl_tx_bit`: 0 gives `hdlc_bit`, 1 gives the message generator, 2 gives `ext_bit`, 3 gives a constant 1.
- R3: With source 1 and the enable bit CTRL[2] set, each `tx_req` pulse advances through the message 0, c5, c4, c3, c2, c1, c0, 0, then eight ones, and the message repeats. While the enable bit is clear the output is 1 and the next enabled message starts again from its first bit.
- R4: The code (TXCODE, address 1, bits [5:0]) is taken at the first bit of each message, so a write made in the middle of a message shows only from the next message onward.
- R5: A receive message is recognised when the last 16 bits strobed by `dl_rx_vld` form the frame 0, six code bits with the most significant first, 0, eight ones.
- R6: A recognised code is accepted when at least VOTE_MIN of the last VOTE_WIN recognised messages, the newest included, carry it and it differs from the stored code. It is then readable in RXCODE (address 3, bits [5:0]).
- R7: Acceptance of a new code sets bit 0 of LATCH (address 4) and bit 0 of STATUS (address 5). Further repetitions of the stored code set nothing.
- R8: When the accepted code equals MATCH (address 2, bits [5:0]), bit 1 of LATCH and STATUS is set, once per transition into that code.
- R9: Reading LATCH clears LATCH, and reading STATUS clears STATUS. A bit that is being set in the same cycle stays set.
- R10: `irq` is high exactly when some STATUS bit is set whose MASK bit (address 6, bits [1:0], where 1 means enabled) is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; triggers the clear on read |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| tx_req | input | 1 | Request for the next transmit data-link bit |
| hdlc_bit | input | 1 | Data-link bit from the HDLC controller |
| ext_bit | input | 1 | Data-link bit from the external pin |
| dl_tx_bit | output | 1 | Selected transmit data-link bit |
| dl_rx_bit | input | 1 | Received data-link bit |
| dl_rx_vld | input | 1 | Strobe that qualifies `dl_rx_bit` |
| irq | output | 1 | Interrupt, OR of the unmasked status bits |

## Verification
The assertions check the following properties on every cycle:
- The transmit bit counter restarts whenever the enable bit is off and wraps after the last bit of a message.
- A recognised message never appears without a strobed bit just before it.
- The stored receive code changes only on a cycle that carries a recognised message.
- The latch bits hold unless they are set or cleared, and a clearing read with no new event leaves them at zero.

Other behaviours need the bench scenarios to show them:
- The exact transmit bit order.
- The moment a mid-message code write takes effect.
- The voting threshold, checked one message short of it and then at it.
- The single match event when the code moves back to the match value.
- The masking of the interrupt.

// File: rtl/bom_pkg.sv
package bom_pkg;
  localparam int CODE_W = 6;
  localparam int ONES_W = 8;
  localparam int MSG_W  = CODE_W + ONES_W + 2;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int EVT_N  = 2;

  typedef enum logic [1:0] {
    SRC_HDLC = 2'd0,
    SRC_GEN  = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_IDLE = 2'd3
  } src_e;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_TXCODE = 3'd1;
  localparam logic [ADDR_W-1:0] A_MATCH  = 3'd2;
  localparam logic [ADDR_W-1:0] A_RXCODE = 3'd3;
  localparam logic [ADDR_W-1:0] A_LATCH  = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd5;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd6;

  // Frame as sent: oldest bit at the MSB.
  function automatic logic [MSG_W-1:0] build_msg(input logic [CODE_W-1:0] c);
    return {1'b0, c, 1'b0, {ONES_W{1'b1}}};
  endfunction
endpackage

// File: rtl/bom_tx_gen.sv
module bom_tx_gen
  import bom_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              adv_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              bit_o
);
  localparam int CNT_W = $clog2(MSG_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MSG_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [MSG_W-1:0] msg_q, msg_d;
  logic [MSG_W-1:0] cur;

  // At the first bit the code register is used directly; afterwards the held copy.
  always_comb begin
    cur   = (cnt_q == '0) ? build_msg(code_i) : msg_q;
    bit_o = cur[MSG_W-1];
    cnt_d = cnt_q;
    msg_d = msg_q;
    if (!en_i) begin
      cnt_d = '0;
    end else if (adv_i) begin
      msg_d = {cur[MSG_W-2:0], 1'b1};
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      msg_q <= '1;
    end else begin
      cnt_q <= cnt_d;
      msg_q <= msg_d;
    end
  end

  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (en_i && adv_i && cnt_q == LAST) |=> (cnt_q == '0));
endmodule

// File: rtl/bom_rx_detect.sv
module bom_rx_detect
  import bom_pkg::*;
#(
  parameter int VOTE_WIN = 10,
  parameter int VOTE_MIN = 7
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              vld_i,
  output logic              hit_o,
  output logic [CODE_W-1:0] cand_o,
  output logic              vote_ok_o
);
  localparam int HN = VOTE_WIN - 1;
  localparam int VW = $clog2(VOTE_WIN + 1);

  logic [MSG_W-1:0]  win_q, win_d;
  logic              hit_q, hit_d;
  logic [CODE_W-1:0] cand_q, cand_d;
  logic [CODE_W-1:0] hist_q [HN];
  logic [HN-1:0]     hval_q;
  logic [HN-1:0]     agree;
  logic [VW-1:0]     votes;

  always_comb begin
    win_d  = vld_i ? {win_q[MSG_W-2:0], bit_i} : win_q;
    hit_d  = vld_i && !win_d[MSG_W-1] && !win_d[ONES_W] && (&win_d[ONES_W-1:0]);
    cand_d = win_d[ONES_W+CODE_W:ONES_W+1];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '1;
      hit_q  <= 1'b0;
      cand_q <= '0;
    end else begin
      win_q  <= win_d;
      hit_q  <= hit_d;
      cand_q <= cand_d;
    end
  end

  // History of earlier recognised codes, newest in slot 0.
  for (genvar i = 0; i < HN; i++) begin : g_hist
    assign agree[i] = hval_q[i] && (hist_q[i] == cand_q);
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        hist_q[i] <= '0;
        hval_q[i] <= 1'b0;
      end else if (hit_q) begin
        if (i == 0) begin
          hist_q[i] <= cand_q;
          hval_q[i] <= 1'b1;
        end else begin
          hist_q[i] <= hist_q[(i == 0) ? 0 : i-1];
          hval_q[i] <= hval_q[(i == 0) ? 0 : i-1];
        end
      end
    end
  end

  assign votes     = VW'($countones(agree)) + VW'(1);
  assign vote_ok_o = (votes >= VW'(VOTE_MIN));
  assign hit_o     = hit_q;
  assign cand_o    = cand_q;

  p_hit_after_bit_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    hit_q |-> $past(vld_i));
endmodule

// File: rtl/bom_status.sv
module bom_status
  import bom_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [EVT_N-1:0] set_i,
  input  logic             clr_latch_i,
  input  logic             clr_stat_i,
  input  logic [EVT_N-1:0] mask_i,
  output logic [EVT_N-1:0] latch_o,
  output logic [EVT_N-1:0] stat_o,
  output logic             irq_o
);
  logic [EVT_N-1:0] latch_q, latch_d, stat_q, stat_d;

  // A new event wins over a clearing read in the same cycle.
  always_comb begin
    latch_d = (latch_q & ~{EVT_N{clr_latch_i}}) | set_i;
    stat_d  = (stat_q  & ~{EVT_N{clr_stat_i}})  | set_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      stat_q  <= '0;
    end else begin
      latch_q <= latch_d;
      stat_q  <= stat_d;
    end
  end

  assign latch_o = latch_q;
  assign stat_o  = stat_q;
  assign irq_o   = |(stat_q & mask_i);

  p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (set_i == '0 && !clr_latch_i) |=> $stable(latch_q));
  p_latch_clear_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (set_i == '0 && clr_latch_i) |=> (latch_q == '0));
endmodule

// File: rtl/bom_engine.sv
module bom_engine
  import bom_pkg::*;
#(
  parameter int VOTE_WIN = 10,
  parameter int VOTE_MIN = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tx_req,
  input  logic              hdlc_bit,
  input  logic              ext_bit,
  output logic              dl_tx_bit,
  input  logic              dl_rx_bit,
  input  logic              dl_rx_vld,
  output logic              irq
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  src_e              src_q, src_d;
  logic              en_q, en_d;
  logic [CODE_W-1:0] txcode_q, txcode_d, match_q, match_d, rxcode_q, rxcode_d;
  logic [EVT_N-1:0]  mask_q, mask_d;
  logic              have_q, have_d;
  logic              gen_bit, hit, vote_ok, accept;
  logic [CODE_W-1:0] cand;
  logic [EVT_N-1:0]  evt, latch, stat;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:CODE_W];

  always_comb begin
    src_d    = src_q;
    en_d     = en_q;
    txcode_d = txcode_q;
    match_d  = match_q;
    mask_d   = mask_q;
    if (reg_wr) begin
      case (reg_addr)
        A_CTRL:   begin src_d = src_e'(reg_wdata[1:0]); en_d = reg_wdata[2]; end
        A_TXCODE: txcode_d = reg_wdata[CODE_W-1:0];
        A_MATCH:  match_d  = reg_wdata[CODE_W-1:0];
        A_MASK:   mask_d   = reg_wdata[EVT_N-1:0];
        default:  ;
      endcase
    end
    accept   = hit && vote_ok && (!have_q || cand != rxcode_q);
    rxcode_d = accept ? cand : rxcode_q;
    have_d   = have_q || accept;
    evt      = {accept && (cand == match_q), accept};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= SRC_HDLC;
      en_q     <= 1'b0;
      txcode_q <= '0;
      match_q  <= '0;
      mask_q   <= '0;
      rxcode_q <= '0;
      have_q   <= 1'b0;
    end else begin
      src_q    <= src_d;
      en_q     <= en_d;
      txcode_q <= txcode_d;
      match_q  <= match_d;
      mask_q   <= mask_d;
      rxcode_q <= rxcode_d;
      have_q   <= have_d;
    end
  end

  bom_tx_gen u_tx (
    .clk    (clk),
    .rst_ni (rst_ni),
    .en_i   (en_q),
    .adv_i  (tx_req && src_q == SRC_GEN),
    .code_i (txcode_q),
    .bit_o  (gen_bit)
  );

  bom_rx_detect #(.VOTE_WIN(VOTE_WIN), .VOTE_MIN(VOTE_MIN)) u_rx (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .bit_i     (dl_rx_bit),
    .vld_i     (dl_rx_vld),
    .hit_o     (hit),
    .cand_o    (cand),
    .vote_ok_o (vote_ok)
  );

  bom_status u_st (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .set_i       (evt),
    .clr_latch_i (reg_rd && reg_addr == A_LATCH),
    .clr_stat_i  (reg_rd && reg_addr == A_STAT),
    .mask_i      (mask_q),
    .latch_o     (latch),
    .stat_o      (stat),
    .irq_o       (irq)
  );

  always_comb begin
    case (src_q)
      SRC_HDLC: dl_tx_bit = hdlc_bit;
      SRC_GEN:  dl_tx_bit = en_q ? gen_bit : 1'b1;
      SRC_EXT:  dl_tx_bit = ext_bit;
      default:  dl_tx_bit = 1'b1;
    endcase
    case (reg_addr)
      A_CTRL:   reg_rdata = DATA_W'({en_q, src_q});
      A_TXCODE: reg_rdata = DATA_W'(txcode_q);
      A_MATCH:  reg_rdata = DATA_W'(match_q);
      A_RXCODE: reg_rdata = DATA_W'(rxcode_q);
      A_LATCH:  reg_rdata = DATA_W'(latch);
      A_STAT:   reg_rdata = DATA_W'(stat);
      A_MASK:   reg_rdata = DATA_W'(mask_q);
      default:  reg_rdata = '0;
    endcase
  end

  p_rxcode_hold_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    !hit |=> $stable(rxcode_q));
endmodule

// File: tb/sim_bom_engine.sv
module sim_bom_engine;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tx_req = 1'b0, hdlc_bit = 1'b0, ext_bit = 1'b0;
  logic       dl_tx_bit;
  logic       dl_rx_bit = 1'b1, dl_rx_vld = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {logic b; string tag;} exp_t;
  exp_t exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  bom_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_req(tx_req), .hdlc_bit(hdlc_bit), .ext_bit(ext_bit),
    .dl_tx_bit(dl_tx_bit), .dl_rx_bit(dl_rx_bit), .dl_rx_vld(dl_rx_vld),
    .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: each requested bit is compared with the next expected item.
  always @(negedge clk) begin
    if (tx_req) begin
      if (exp_q.size() == 0) begin
        chk("R3 unexpected request", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, int'(dl_tx_bit), int'(e.b));
      end
    end
  end

  function automatic logic msg_bit(input logic [5:0] c, input int i);
    if (i == 0 || i == 7) return 1'b0;
    if (i <= 6) return c[6-i];
    return 1'b1;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(posedge clk); #1; reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); d = reg_rdata;
    @(posedge clk); #1; reg_rd = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input int exp, input string tag);
    logic [7:0] d;
    rd(a, d);
    chk(tag, int'(d), exp);
  endtask

  // Driver: push the expected bit, then request it.
  task automatic req_bit(input logic e, input string tag);
    exp_t x;
    x.b = e; x.tag = tag;
    exp_q.push_back(x);
    @(posedge clk); #1; tx_req = 1'b1;
    @(posedge clk); #1; tx_req = 1'b0;
  endtask

  task automatic req_bits(input logic [5:0] c, input int from, input int to, input string tag);
    for (int i = from; i <= to; i++) req_bit(msg_bit(c, i), tag);
  endtask

  task automatic rx_msg(input logic [5:0] c);
    for (int i = 0; i < 16; i++) begin
      @(posedge clk); #1; dl_rx_vld = 1'b1; dl_rx_bit = msg_bit(c, i);
    end
    @(posedge clk); #1; dl_rx_vld = 1'b0; dl_rx_bit = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  task automatic rx_n(input logic [5:0] c, input int n);
    for (int k = 0; k < n; k++) rx_msg(c);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk("watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] ca, cb, cx, cy;
    ca = 6'b100110; cb = 6'b011001; cx = 6'b101101; cy = 6'b010011;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    @(negedge clk); chk("R1 irq after reset", int'(irq), 0);
    hdlc_bit = 1'b1; #1; chk("R1 tx follows hdlc high", int'(dl_tx_bit), 1);
    hdlc_bit = 1'b0; #1; chk("R1 tx follows hdlc low", int'(dl_tx_bit), 0);
    for (int a = 0; a < 7; a++) rd_chk(3'(a), 0, "R1 register zero");

    // R2 source selection
    wr(3'd0, 8'h03); @(negedge clk); chk("R2 idle source", int'(dl_tx_bit), 1);
    wr(3'd0, 8'h02);
    ext_bit = 1'b0; @(negedge clk); chk("R2 ext low", int'(dl_tx_bit), 0);
    ext_bit = 1'b1; @(negedge clk); chk("R2 ext high", int'(dl_tx_bit), 1);
    wr(3'd0, 8'h00); hdlc_bit = 1'b1; ext_bit = 1'b0;
    @(negedge clk); chk("R2 hdlc source", int'(dl_tx_bit), 1);
    hdlc_bit = 1'b0;

    // R3 generator disabled gives ones, then two full messages
    wr(3'd1, {2'b00, cx});
    wr(3'd0, 8'h01);
    req_bit(1'b1, "R3 disabled idle");
    req_bit(1'b1, "R3 disabled idle");
    wr(3'd0, 8'h05);
    req_bits(cx, 0, 15, "R3 first message");
    req_bits(cx, 0, 15, "R3 repeat message");
    // restart after disable mid-message
    req_bits(cx, 0, 4, "R3 partial");
    wr(3'd0, 8'h01); wr(3'd0, 8'h05);
    req_bits(cx, 0, 15, "R3 restart from first bit");

    // R4 code written mid-message
    req_bits(cx, 0, 3, "R4 old code head");
    wr(3'd1, {2'b00, cy});
    req_bits(cx, 4, 15, "R4 old code tail");
    req_bits(cy, 0, 15, "R4 new code next message");
    @(negedge clk); chk("R3 scoreboard drained", exp_q.size(), 0);
    wr(3'd0, 8'h00);

    // R5/R6/R7/R8 receive and vote
    wr(3'd2, {2'b00, ca});
    wr(3'd6, 8'h03);
    rx_n(ca, 6);
    @(negedge clk); chk("R6 below threshold irq", int'(irq), 0);
    rd_chk(3'd4, 0, "R6 no event below threshold");
    rx_msg(ca);
    @(negedge clk); chk("R10 irq after accept", int'(irq), 1);
    rd_chk(3'd3, int'(ca), "R6 stored code");
    rd_chk(3'd4, 3, "R7 R8 latch after accept");
    rd_chk(3'd4, 0, "R9 latch cleared by read");
    @(negedge clk); chk("R10 irq held by status", int'(irq), 1);
    rd_chk(3'd5, 3, "R7 status after accept");
    @(negedge clk); chk("R9 R10 irq after status read", int'(irq), 0);
    rd_chk(3'd5, 0, "R9 status cleared by read");
    rx_n(ca, 3);
    rd_chk(3'd4, 0, "R7 repetition sets nothing");

    // R5 broken framing is not recognised (last ones bit zero)
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < 16; i++) begin
        @(posedge clk); #1; dl_rx_vld = 1'b1;
        dl_rx_bit = (i == 15) ? 1'b0 : msg_bit(cb, i);
      end
    end
    @(posedge clk); #1; dl_rx_vld = 1'b0; dl_rx_bit = 1'b1;
    repeat (3) @(posedge clk);
    rd_chk(3'd3, int'(ca), "R5 bad frames ignored");

    // R10 mask only match; non-matching code
    wr(3'd6, 8'h02);
    rx_n(cb, 6);
    rd_chk(3'd4, 0, "R6 six of ten not enough");
    rx_msg(cb);
    @(negedge clk); chk("R10 masked received event", int'(irq), 0);
    rd_chk(3'd3, int'(cb), "R6 new code stored");
    rd_chk(3'd4, 1, "R8 no match for other code");
    rd_chk(3'd5, 1, "R7 status received only");

    // R8 back to match code
    rx_n(ca, 6);
    rd_chk(3'd4, 0, "R6 six of ten back");
    rx_msg(ca);
    @(negedge clk); chk("R10 irq on match", int'(irq), 1);
    rd_chk(3'd4, 3, "R8 match on transition");
    rd_chk(3'd5, 3, "R8 status match");
    rx_n(ca, 2);
    rd_chk(3'd4, 0, "R8 match fires once");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule